// File: doc/BRIEF.md
# Timer Interrupt Flag Grouping Unit

This block keeps the five event flags of a 16-bit timer: two capture flags, two compare flags and one overflow flag. Single-cycle pulses from the capture, compare and overflow logic set the flags. Software reads the flags from the upper five bits of a status register. A control register holds three enables. One enable is shared by both capture flags, one by both compare flags, and one covers overflow. These enables gate the flags onto three separate interrupt request lines.

The unit also drives a vector address for the highest-priority pending request. Capture has the highest priority, then compare, then overflow. A flag clears only through a two-step sequence. Software first reads the status register while the flag is set, and then accesses the data register that belongs to that flag. Writing the status register never changes the flags. The counter and the capture and compare datapaths lie outside this block.

Top module: `timer_irq_hub`

## Requirements
- R1: While reset is asserted and right after it is released, all flags and enables are zero, no request line is high, vec_valid is 0 and vec_addr is 0.
- R2: A one-cycle pulse on cap_evt[0], cap_evt[1], cmp_evt[0], cmp_evt[1] or ovf_evt sets its flag on the next clock edge. A read of the status register (address 0x13) returns these flags in bits 7, 6, 5, 4 and 3, in that order. Bits 2 to 0 read as zero.
- R3: A write to the control register (address 0x12) stores bit 7 as the capture enable, bit 6 as the compare enable and bit 5 as the overflow enable. A read returns these three bits in the same positions, and the other bits read as zero. A read of any address other than 0x12 or 0x13 returns zero.
- R4: irq_cap is high exactly when the capture enable is set and either capture flag is set. irq_cmp follows the same rule with the compare enable and the compare flags. irq_ovf is high exactly when the overflow enable and the overflow flag are both set.
- R5: vec_valid is high when any request line is high. vec_addr is 0x3FF8 for capture, 0x3FF6 for compare and 0x3FF4 for overflow. When several requests are pending, capture wins over compare and compare wins over overflow. With no request pending, vec_addr is 0.
- R6: A flag clears when two steps happen in order: a status read while the flag is set, then a later read or write of that flag's data register. The data registers are at 0x14 (capture 0), 0x15 (capture 1), 0x16 (compare 0), 0x17 (compare 1) and 0x18 (overflow).
- R7: Accessing a data register does not clear its flag in two cases: no status read has happened since the flag was set, or the flag was clear at the last status read.
- R8: A write to the status register leaves every flag unchanged.
- R9: If an event pulse arrives in the same cycle as a clearing access, the flag stays set.
- R10: Accessing one flag's data register leaves all other flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_evt | input | 2 | Capture event pulses, one bit per capture channel |
| cmp_evt | input | 2 | Compare event pulses, one bit per compare channel |
| ovf_evt | input | 1 | Counter overflow pulse |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write access, 0 for a read access |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; valid in the cycle of a read access, zero otherwise |
| irq_cap | output | 1 | Capture interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| vec_valid | output | 1 | High when any request is pending |
| vec_addr | output | 16 | Vector address of the highest-priority pending request |

## Verification
The bench builds the block with its default parameters. These are an 8-bit register port, an 8-bit address, the status register at 0x13, the control register at 0x12, the data registers starting at 0x14, and 16-bit vectors of 0x3FF8, 0x3FF6 and 0x3FF4. With these values, each flag's bit position, each register address and each vector value is a concrete number that a behavioural model can predict on every cycle. A directed sequence covers the orderings that matter. These include clearing access before versus after the status read, an event arriving in the same cycle as its clearing access, status writes, and all three requests pending at once. A random phase then mixes event pulses and register accesses to random addresses.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  // flag slots inside the flag vector, index 0 is the top status bit
  localparam int NFLAG   = 5;
  localparam int CAP_LO  = 0;
  localparam int N_CAP   = 2;
  localparam int CMP_LO  = CAP_LO + N_CAP;
  localparam int N_CMP   = 2;
  localparam int OVF_IDX = CMP_LO + N_CMP;
  localparam int NGROUP  = 3;

  typedef enum logic [1:0] {
    GRP_CAP = 2'd0,
    GRP_CMP = 2'd1,
    GRP_OVF = 2'd2
  } grp_e;
endpackage

// File: rtl/tirq_flag_bank.sv
module tirq_flag_bank #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic          stat_rd_i,
  input  logic [NF-1:0] acc_i,
  output logic [NF-1:0] flag_o
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic f_q, f_d, a_q, a_d, ce;

    always_comb begin
      f_d = f_q;
      a_d = a_q;
      // a status read arms the clear only for a flag that is set now
      if (stat_rd_i) a_d = f_q;
      if (acc_i[g] && a_q) begin
        f_d = 1'b0;
        a_d = 1'b0;
      end
      // a fresh event always wins over a clear
      if (set_i[g]) f_d = 1'b1;
    end

    assign ce = stat_rd_i | acc_i[g] | set_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        f_q <= 1'b0;
        a_q <= 1'b0;
      end else if (ce) begin
        f_q <= f_d;
        a_q <= a_d;
      end
    end

    assign flag_o[g] = f_q;
  end
endmodule

// File: rtl/tirq_ctrl_reg.sv
module tirq_ctrl_reg #(
  parameter int DATA_W = 8,
  parameter int NG     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NG-1:0]     en_o
);
  logic [NG-1:0] en_q, en_d;
  logic          unused_low;

  always_comb begin
    en_d = en_q;
    for (int k = 0; k < NG; k++) en_d[k] = wdata_i[DATA_W-1-k];
  end

  assign unused_low = ^wdata_i[DATA_W-NG-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (wr_i) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/tirq_prio_vec.sv
module tirq_prio_vec
  import tirq_pkg::*;
#(
  parameter int             VEC_W   = 16,
  parameter logic [VEC_W-1:0] VEC_CAP = 16'h3FF8,
  parameter logic [VEC_W-1:0] VEC_CMP = 16'h3FF6,
  parameter logic [VEC_W-1:0] VEC_OVF = 16'h3FF4
) (
  input  logic [NFLAG-1:0]  flag_i,
  input  logic [NGROUP-1:0] en_i,
  output logic [NGROUP-1:0] req_o,
  output logic              vec_valid_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [NGROUP-1:0] pend;

  assign pend[GRP_CAP] = |flag_i[CAP_LO +: N_CAP];
  assign pend[GRP_CMP] = |flag_i[CMP_LO +: N_CMP];
  assign pend[GRP_OVF] = flag_i[OVF_IDX];
  assign req_o         = pend & en_i;

  always_comb begin
    vec_valid_o = |req_o;
    vec_o       = '0;
    if (req_o[GRP_CAP])      vec_o = VEC_CAP;
    else if (req_o[GRP_CMP]) vec_o = VEC_CMP;
    else if (req_o[GRP_OVF]) vec_o = VEC_OVF;
  end
endmodule

// File: rtl/timer_irq_hub.sv
module timer_irq_hub
  import tirq_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter int                VEC_W     = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h12,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h13,
  parameter logic [ADDR_W-1:0] DATA_BASE = 8'h14,
  parameter logic [VEC_W-1:0]  VEC_CAP   = 16'h3FF8,
  parameter logic [VEC_W-1:0]  VEC_CMP   = 16'h3FF6,
  parameter logic [VEC_W-1:0]  VEC_OVF   = 16'h3FF4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CAP-1:0]  cap_evt,
  input  logic [N_CMP-1:0]  cmp_evt,
  input  logic              ovf_evt,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_cap,
  output logic              irq_cmp,
  output logic              irq_ovf,
  output logic              vec_valid,
  output logic [VEC_W-1:0]  vec_addr
);
  logic [NFLAG-1:0]  set_v, acc_v, flag_q;
  logic [NGROUP-1:0] en_q, req;
  logic              hit_stat, hit_ctrl, stat_rd, ctrl_wr, rd_en;

  assign set_v = {ovf_evt, cmp_evt[1], cmp_evt[0], cap_evt[1], cap_evt[0]};

  assign hit_stat = bus_sel && (bus_addr == STAT_ADDR);
  assign hit_ctrl = bus_sel && (bus_addr == CTRL_ADDR);
  assign stat_rd  = hit_stat && !bus_wr;
  assign ctrl_wr  = hit_ctrl && bus_wr;
  assign rd_en    = bus_sel && !bus_wr;

  for (genvar g = 0; g < NFLAG; g++) begin : g_dec
    assign acc_v[g] = bus_sel && (bus_addr == ADDR_W'(DATA_BASE + g));
  end

  tirq_flag_bank #(.NF(NFLAG)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_v),
    .stat_rd_i (stat_rd),
    .acc_i     (acc_v),
    .flag_o    (flag_q)
  );

  tirq_ctrl_reg #(.DATA_W(DATA_W), .NG(NGROUP)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (ctrl_wr),
    .wdata_i (bus_wdata),
    .en_o    (en_q)
  );

  tirq_prio_vec #(
    .VEC_W(VEC_W), .VEC_CAP(VEC_CAP), .VEC_CMP(VEC_CMP), .VEC_OVF(VEC_OVF)
  ) u_prio (
    .flag_i      (flag_q),
    .en_i        (en_q),
    .req_o       (req),
    .vec_valid_o (vec_valid),
    .vec_o       (vec_addr)
  );

  assign irq_cap = req[GRP_CAP];
  assign irq_cmp = req[GRP_CMP];
  assign irq_ovf = req[GRP_OVF];

  always_comb begin
    bus_rdata = '0;
    if (rd_en && hit_stat) begin
      for (int k = 0; k < NFLAG; k++) bus_rdata[DATA_W-1-k] = flag_q[k];
    end else if (rd_en && hit_ctrl) begin
      for (int k = 0; k < NGROUP; k++) bus_rdata[DATA_W-1-k] = en_q[k];
    end
  end
endmodule

// File: rtl/tirq_checker.sv
module tirq_checker
  import tirq_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                VEC_W     = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h13,
  parameter logic [ADDR_W-1:0] DATA_BASE = 8'h14,
  parameter logic [VEC_W-1:0]  VEC_CAP   = 16'h3FF8,
  parameter logic [VEC_W-1:0]  VEC_CMP   = 16'h3FF6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CAP-1:0]  cap_evt,
  input logic              ovf_evt,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_cap,
  input logic              irq_cmp,
  input logic              irq_ovf,
  input logic              vec_valid,
  input logic [VEC_W-1:0]  vec_addr,
  input logic [NFLAG-1:0]  flag_q,
  input logic [NGROUP-1:0] en_q
);
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!vec_valid && flag_q == '0 && en_q == '0));

  a_r4_cap_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cap |-> (en_q[GRP_CAP] && (flag_q[0] || flag_q[1])));

  a_r5_cap_first: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cap |-> (vec_addr == VEC_CAP));

  a_r5_cmp_second: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cmp && !irq_cap) |-> (vec_addr == VEC_CMP));

  a_r5_valid_any: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid == (irq_cap || irq_cmp || irq_ovf));

  a_r2_cap0_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt[0] |=> flag_q[0]);

  a_r9_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag_q[OVF_IDX]);

  a_r8_stat_wr_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == STAT_ADDR) |=>
      ((flag_q & $past(flag_q)) == $past(flag_q)));

  for (genvar g = 0; g < NFLAG; g++) begin : g_fall
    a_r10_fall_needs_own_access: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[g]) |-> $past(bus_sel && bus_addr == ADDR_W'(DATA_BASE + g)));
  end
endmodule

bind timer_irq_hub tirq_checker #(
  .ADDR_W(ADDR_W), .VEC_W(VEC_W), .STAT_ADDR(STAT_ADDR), .DATA_BASE(DATA_BASE),
  .VEC_CAP(VEC_CAP), .VEC_CMP(VEC_CMP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .ovf_evt(ovf_evt),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .irq_cap(irq_cap), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf),
  .vec_valid(vec_valid), .vec_addr(vec_addr), .flag_q(flag_q), .en_q(en_q)
);

// File: tb/timer_irq_hub_test.sv
`timescale 1ns/1ps
module timer_irq_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cap_evt = '0;
  logic [1:0]  cmp_evt = '0;
  logic        ovf_evt = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_cap, irq_cmp, irq_ovf, vec_valid;
  logic [15:0] vec_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  bit cyc_on = 0;

  // behavioural reference state
  bit m_f[5];
  bit m_a[5];
  bit m_en[3];

  always #10 clk = ~clk;

  timer_irq_hub uut (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .cmp_evt(cmp_evt), .ovf_evt(ovf_evt),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_cap(irq_cap), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf),
    .vec_valid(vec_valid), .vec_addr(vec_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 5; i++) begin m_f[i] = 0; m_a[i] = 0; end
      for (int i = 0; i < 3; i++) m_en[i] = 0;
    end else begin
      bit ev[5];
      ev[0] = cap_evt[0]; ev[1] = cap_evt[1];
      ev[2] = cmp_evt[0]; ev[3] = cmp_evt[1]; ev[4] = ovf_evt;
      for (int i = 0; i < 5; i++) begin
        bit nf, na;
        nf = m_f[i]; na = m_a[i];
        if (bus_sel && !bus_wr && bus_addr == 8'h13) na = m_f[i];
        if (bus_sel && bus_addr == 8'h14 + i && m_a[i]) begin nf = 0; na = 0; end
        if (ev[i]) nf = 1;
        m_f[i] = nf; m_a[i] = na;
      end
      if (bus_sel && bus_wr && bus_addr == 8'h12)
        for (int i = 0; i < 3; i++) m_en[i] = bus_wdata[7-i];
    end
  end

  // per-cycle comparison, a quarter period after the input change
  always @(negedge clk) begin
    #5;
    if (cyc_on) begin
      logic ec, em, eo;
      logic [15:0] ev_a;
      logic [7:0] er;
      ec = m_en[0] & (m_f[0] | m_f[1]);
      em = m_en[1] & (m_f[2] | m_f[3]);
      eo = m_en[2] & m_f[4];
      ev_a = ec ? 16'h3FF8 : em ? 16'h3FF6 : eo ? 16'h3FF4 : 16'h0000;
      er = 8'h00;
      if (bus_sel && !bus_wr && bus_addr == 8'h13)
        er = {m_f[0], m_f[1], m_f[2], m_f[3], m_f[4], 3'b000};
      else if (bus_sel && !bus_wr && bus_addr == 8'h12)
        er = {m_en[0], m_en[1], m_en[2], 5'b00000};
      chk("R2/R3 rdata", {24'h0, bus_rdata}, {24'h0, er});
      chk("R4 irq lines", {29'h0, irq_cap, irq_cmp, irq_ovf}, {29'h0, ec, em, eo});
      chk("R5 vec_valid", {31'h0, vec_valid}, {31'h0, ec | em | eo});
      chk("R5 vec_addr", {16'h0, vec_addr}, {16'h0, ev_a});
    end
  end

  task automatic idle();
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; cap_evt = '0; cmp_evt = '0; ovf_evt = 0;
  endtask

  task automatic access(input bit wr, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cap_evt = '0; cmp_evt = '0; ovf_evt = 0;
    bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    access(0, a, 8'h00);
    #5;
    chk(tag, {24'h0, bus_rdata}, {24'h0, exp});
  endtask

  task automatic pulse(input logic [1:0] c, input logic [1:0] m, input bit o);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    cap_evt = c; cmp_evt = m; ovf_evt = o;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk("R1 vec_valid in reset", {31'h0, vec_valid}, 32'h0);
    chk("R1 vec_addr in reset", {16'h0, vec_addr}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    cyc_on = 1;
    read_chk("R1 status after reset", 8'h13, 8'h00);
    read_chk("R1 ctrl after reset", 8'h12, 8'h00);

    pulse(2'b01, 2'b00, 0);
    idle();
    #5 chk("R4 disabled capture stays quiet", {31'h0, irq_cap}, 32'h0);
    read_chk("R2 capture 0 at bit 7", 8'h13, 8'h80);

    access(1, 8'h12, 8'hFF);
    read_chk("R3 ctrl readback", 8'h12, 8'hE0);
    idle();
    #5 chk("R5 capture vector", {16'h0, vec_addr}, 32'h3FF8);

    pulse(2'b00, 2'b00, 1);
    read_chk("R2 overflow at bit 3", 8'h13, 8'h88);
    idle();
    #5 chk("R5 capture beats overflow", {16'h0, vec_addr}, 32'h3FF8);

    access(1, 8'h13, 8'h00);
    read_chk("R8 status write ignored", 8'h13, 8'h88);

    pulse(2'b00, 2'b10, 0);
    access(0, 8'h17, 8'h00);
    read_chk("R7 unarmed compare 1 kept", 8'h13, 8'h98);

    access(0, 8'h14, 8'h00);
    read_chk("R6/R10 capture 0 cleared, others kept", 8'h13, 8'h18);
    idle();
    #5 chk("R5 compare vector", {16'h0, vec_addr}, 32'h3FF6);

    read_chk("R6 arm read", 8'h13, 8'h18);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h18; bus_wdata = 8'h00; ovf_evt = 1;
    read_chk("R9 overflow kept on event during clear", 8'h13, 8'h18);

    access(0, 8'h17, 8'h00);
    read_chk("R6 compare 1 cleared", 8'h13, 8'h08);
    idle();
    #5 chk("R5 overflow vector", {16'h0, vec_addr}, 32'h3FF4);
    access(1, 8'h18, 8'h00);
    read_chk("R6 overflow cleared", 8'h13, 8'h00);
    idle();
    #5 chk("R5 nothing pending", {31'h0, vec_valid}, 32'h0);
    read_chk("R3 other address reads zero", 8'h20, 8'h00);

    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      cap_evt = ($urandom % 6 == 0) ? 2'($urandom) : 2'b00;
      cmp_evt = ($urandom % 6 == 0) ? 2'($urandom) : 2'b00;
      ovf_evt = ($urandom % 8 == 0);
      bus_sel = ($urandom % 2);
      bus_wr  = ($urandom % 3 == 0);
      case ($urandom % 9)
        0: bus_addr = 8'h12;
        1, 2, 3: bus_addr = 8'h13;
        8: bus_addr = 8'h20;
        default: bus_addr = 8'h14 + 8'($urandom % 5);
      endcase
      bus_wdata = 8'($urandom);
    end
    idle();
    idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule